// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block sits between two priority resolvers and the CPU. One resolver is the primary (master) and one is the secondary (slave), and the secondary's output feeds primary input 2. Each resolver reports its current winning line together with a valid flag and the vector base that has been programmed for it. Register programming stays inside the resolvers. This unit drives the single CPU interrupt line. It tells the primary whether its input 2 has a live secondary request behind it. It produces the 8-bit vector when the CPU acknowledges, and it sends an acknowledge strobe back to each resolver that took part.

When the primary's winner is its cascade input but the secondary has nothing deliverable, the unit flags the request as stale. It raises a drop strobe so that the primary clears its input-2 request and chooses again, and it keeps the CPU line low for that stale winner, so a lower-priority primary line can still be delivered. If an acknowledge finds a request that has vanished, the unit returns a fixed spurious vector: line 7 of the primary if the primary has nothing, or line 7 of the secondary if the cascade path is empty.

A control machine with three states orders each acknowledge. `IDLE` waits for an acknowledge. The transition `accept` (acknowledge seen in `IDLE`) leads to `DELIVER`, the single cycle in which the vector is valid and the strobes fire. The transition `retire` leads unconditionally to `SETTLE`, one quiet cycle in which the resolvers update their state. The transition `resume` leads unconditionally back to `IDLE`, where the CPU line is evaluated again.

Top module: `cascade_ack_unit`

## Requirements
- R1: `cascade_req` equals `s_pend_valid` in every cycle (combinational).
- R2: When `m_pend_valid` is 1, `m_pend_line` is 2 and `s_pend_valid` is 0, `drop_cascade` is 1 in that same cycle. `cpu_int` is 0 in the following cycle for that request. In every other case `drop_cascade` is 0.
- R3: An acknowledge accepted while `m_pend_valid` is 0 yields the vector `{m_base[7:3],3'b111}`, and neither `m_ack` nor `s_ack` pulses.
- R4: An acknowledge accepted while the primary winner is line 2 and `s_pend_valid` is 1 yields `{s_base[7:3],s_pend_line}`. Both `m_ack` and `s_ack` pulse, with `m_ack_line`=2 and `s_ack_line`=`s_pend_line`.
- R5: An acknowledge accepted while the primary winner is line 2 and `s_pend_valid` is 0 yields `{s_base[7:3],3'b111}`, and only `m_ack` pulses.
- R6: An acknowledge accepted while the primary winner is a line L other than 2 yields `{m_base[7:3],L}`. Only `m_ack` pulses, with `m_ack_line`=L.
- R7: The low three bits of `m_base` and `s_base` never reach `vec_out`.
- R8: `inta` sampled high in `IDLE` makes `vec_valid`, and the selected ack strobes, high in the next cycle for exactly one cycle. `vec_out`, `m_ack_line` and `s_ack_line` hold their values until the next accepted acknowledge.
- R9: `cpu_int` is registered. In the cycle after an edge where the machine enters or stays in `IDLE`, it equals "primary valid and not stale", sampled before that edge. It is 0 during `DELIVER` and `SETTLE`.
- R10: `inta` seen in `DELIVER` or `SETTLE` is ignored. Holding `inta` high for three cycles gives exactly one `vec_valid` pulse.
- R11: While `rst_n` is low, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_pend_valid | input | 1 | Primary resolver has a deliverable winner |
| m_pend_line | input | 3 | Primary winning line |
| m_base | input | 8 | Primary vector base (low 3 bits ignored) |
| s_pend_valid | input | 1 | Secondary resolver has a deliverable winner |
| s_pend_line | input | 3 | Secondary winning line |
| s_base | input | 8 | Secondary vector base (low 3 bits ignored) |
| inta | input | 1 | CPU acknowledge request |
| cascade_req | output | 1 | Level for primary input 2 |
| drop_cascade | output | 1 | Tells the primary to clear a stale input-2 request |
| cpu_int | output | 1 | CPU interrupt line |
| vec_valid | output | 1 | Vector valid, one-cycle pulse |
| vec_out | output | 8 | Delivered vector |
| m_ack | output | 1 | Acknowledge strobe to primary |
| m_ack_line | output | 3 | Line acknowledged on primary |
| s_ack | output | 1 | Acknowledge strobe to secondary |
| s_ack_line | output | 3 | Line acknowledged on secondary |

## Verification
The assertions assume that each resolver reports a stable winner between clock edges, and that the CPU raises `inta` only as a level sampled on the clock. They make no assumption about how a resolver reacts to `drop_cascade` or to the strobes. The stimulus therefore changes every input just after a rising edge and plays the role of both resolvers. It withdraws or keeps requests by hand across the deliver and settle cycles. Stale cascade cases, empty acknowledges and held acknowledges are all produced deliberately.

// File: rtl/cascade_ack_pkg.sv
package cascade_ack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DELIVER = 2'd1,
        ST_SETTLE  = 2'd2
    } ack_state_t;
endpackage

// File: rtl/cas_cascade_check.sv
module cas_cascade_check #(
    parameter int LINE_W       = 3,
    parameter int CASCADE_LINE = 2
) (
    input  logic              m_valid,
    input  logic [LINE_W-1:0] m_line,
    input  logic              s_valid,
    output logic              stale,
    output logic              deliverable
);
    localparam logic [LINE_W-1:0] CAS = LINE_W'(CASCADE_LINE);

    logic picks_cascade;

    always_comb begin
        picks_cascade = m_valid && (m_line == CAS);
        stale         = picks_cascade && !s_valid;
        deliverable   = m_valid && !stale;
    end
endmodule

// File: rtl/cas_vector_sel.sv
module cas_vector_sel #(
    parameter int LINE_W       = 3,
    parameter int VEC_W        = 8,
    parameter int CASCADE_LINE = 2
) (
    input  logic              m_valid,
    input  logic [LINE_W-1:0] m_line,
    input  logic [VEC_W-1:0]  m_base,
    input  logic              s_valid,
    input  logic [LINE_W-1:0] s_line,
    input  logic [VEC_W-1:0]  s_base,
    output logic [VEC_W-1:0]  vec,
    output logic              want_m_ack,
    output logic              want_s_ack
);
    localparam int                BASE_W = VEC_W - LINE_W;
    localparam logic [LINE_W-1:0] CAS    = LINE_W'(CASCADE_LINE);
    localparam logic [LINE_W-1:0] SPUR   = {LINE_W{1'b1}};

    logic [BASE_W-1:0] m_hi;
    logic [BASE_W-1:0] s_hi;

    always_comb begin
        m_hi = m_base[VEC_W-1:LINE_W];
        s_hi = s_base[VEC_W-1:LINE_W];
        if (!m_valid) begin
            vec        = {m_hi, SPUR};
            want_m_ack = 1'b0;
            want_s_ack = 1'b0;
        end else if (m_line == CAS) begin
            want_m_ack = 1'b1;
            want_s_ack = s_valid;
            vec        = s_valid ? {s_hi, s_line} : {s_hi, SPUR};
        end else begin
            vec        = {m_hi, m_line};
            want_m_ack = 1'b1;
            want_s_ack = 1'b0;
        end
    end
endmodule

// File: rtl/cas_ack_fsm.sv
module cas_ack_fsm
    import cascade_ack_pkg::*;
#(
    parameter int LINE_W = 3,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inta,
    input  logic              deliverable,
    input  logic [VEC_W-1:0]  sel_vec,
    input  logic              sel_m_ack,
    input  logic              sel_s_ack,
    input  logic [LINE_W-1:0] m_line,
    input  logic [LINE_W-1:0] s_line,
    output logic              cpu_int,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_out,
    output logic              m_ack,
    output logic [LINE_W-1:0] m_ack_line,
    output logic              s_ack,
    output logic [LINE_W-1:0] s_ack_line
);
    ack_state_t state_q;
    ack_state_t state_d;
    logic       accept;

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (inta) begin
                    state_d = ST_DELIVER;
                    accept  = 1'b1;
                end
            end
            ST_DELIVER: state_d = ST_SETTLE;
            ST_SETTLE:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_int    <= 1'b0;
            vec_valid  <= 1'b0;
            vec_out    <= '0;
            m_ack      <= 1'b0;
            m_ack_line <= '0;
            s_ack      <= 1'b0;
            s_ack_line <= '0;
        end else begin
            cpu_int   <= deliverable && (state_d == ST_IDLE);
            vec_valid <= accept;
            m_ack     <= accept && sel_m_ack;
            s_ack     <= accept && sel_s_ack;
            if (accept) begin
                vec_out    <= sel_vec;
                m_ack_line <= m_line;
                s_ack_line <= s_line;
            end
        end
    end
endmodule

// File: rtl/cascade_ack_unit.sv
module cascade_ack_unit #(
    parameter int LINE_W       = 3,
    parameter int VEC_W        = 8,
    parameter int CASCADE_LINE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_pend_valid,
    input  logic [LINE_W-1:0] m_pend_line,
    input  logic [VEC_W-1:0]  m_base,
    input  logic              s_pend_valid,
    input  logic [LINE_W-1:0] s_pend_line,
    input  logic [VEC_W-1:0]  s_base,
    input  logic              inta,
    output logic              cascade_req,
    output logic              drop_cascade,
    output logic              cpu_int,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_out,
    output logic              m_ack,
    output logic [LINE_W-1:0] m_ack_line,
    output logic              s_ack,
    output logic [LINE_W-1:0] s_ack_line
);
    logic             stale;
    logic             deliverable;
    logic [VEC_W-1:0] sel_vec;
    logic             sel_m_ack;
    logic             sel_s_ack;

    assign cascade_req  = s_pend_valid;
    assign drop_cascade = stale;

    cas_cascade_check #(
        .LINE_W(LINE_W), .CASCADE_LINE(CASCADE_LINE)
    ) u_check (
        .m_valid(m_pend_valid), .m_line(m_pend_line), .s_valid(s_pend_valid),
        .stale(stale), .deliverable(deliverable)
    );

    cas_vector_sel #(
        .LINE_W(LINE_W), .VEC_W(VEC_W), .CASCADE_LINE(CASCADE_LINE)
    ) u_sel (
        .m_valid(m_pend_valid), .m_line(m_pend_line), .m_base(m_base),
        .s_valid(s_pend_valid), .s_line(s_pend_line), .s_base(s_base),
        .vec(sel_vec), .want_m_ack(sel_m_ack), .want_s_ack(sel_s_ack)
    );

    cas_ack_fsm #(
        .LINE_W(LINE_W), .VEC_W(VEC_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .inta(inta), .deliverable(deliverable),
        .sel_vec(sel_vec), .sel_m_ack(sel_m_ack), .sel_s_ack(sel_s_ack),
        .m_line(m_pend_line), .s_line(s_pend_line),
        .cpu_int(cpu_int), .vec_valid(vec_valid), .vec_out(vec_out),
        .m_ack(m_ack), .m_ack_line(m_ack_line),
        .s_ack(s_ack), .s_ack_line(s_ack_line)
    );
endmodule

// File: rtl/cascade_ack_unit_chk.sv
module cascade_ack_unit_chk #(
    parameter int LINE_W       = 3,
    parameter int VEC_W        = 8,
    parameter int CASCADE_LINE = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_pend_valid,
    input logic [LINE_W-1:0] m_pend_line,
    input logic [VEC_W-1:0]  m_base,
    input logic              s_pend_valid,
    input logic [LINE_W-1:0] s_pend_line,
    input logic [VEC_W-1:0]  s_base,
    input logic              inta,
    input logic              cascade_req,
    input logic              drop_cascade,
    input logic              cpu_int,
    input logic              vec_valid,
    input logic [VEC_W-1:0]  vec_out,
    input logic              m_ack,
    input logic [LINE_W-1:0] m_ack_line,
    input logic              s_ack,
    input logic [LINE_W-1:0] s_ack_line
);
    localparam logic [LINE_W-1:0] CAS = LINE_W'(CASCADE_LINE);

    a_r1_cascade_level: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_req == s_pend_valid);

    a_r2_stale_no_int: assert property (@(posedge clk) disable iff (!rst_n)
        (m_pend_valid && m_pend_line == CAS && !s_pend_valid) |=> !cpu_int);

    a_r2_drop_only_stale: assert property (@(posedge clk) disable iff (!rst_n)
        drop_cascade |-> (m_pend_valid && m_pend_line == CAS && !s_pend_valid));

    a_r3_ack_needs_vec: assert property (@(posedge clk) disable iff (!rst_n)
        m_ack |-> vec_valid);

    a_r4_slave_ack_with_master: assert property (@(posedge clk) disable iff (!rst_n)
        s_ack |-> (m_ack && m_ack_line == CAS));

    a_r8_vec_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    a_r8_vec_after_inta: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(inta));

    a_r9_int_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !m_pend_valid |=> !cpu_int);

    a_r9_int_quiet_in_deliver: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !cpu_int);

    a_r10_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> ##1 !vec_valid);
endmodule

bind cascade_ack_unit cascade_ack_unit_chk #(
    .LINE_W(LINE_W), .VEC_W(VEC_W), .CASCADE_LINE(CASCADE_LINE)
) i_chk (.*);

// File: tb/test_cascade_ack_unit.sv
`timescale 1ns/1ps
module test_cascade_ack_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_pend_valid = 1'b0;
    logic [2:0] m_pend_line = '0;
    logic [7:0] m_base = '0;
    logic       s_pend_valid = 1'b0;
    logic [2:0] s_pend_line = '0;
    logic [7:0] s_base = '0;
    logic       inta = 1'b0;
    logic       cascade_req, drop_cascade, cpu_int, vec_valid, m_ack, s_ack;
    logic [7:0] vec_out;
    logic [2:0] m_ack_line, s_ack_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit live = 0;

    always #2 clk = ~clk;

    cascade_ack_unit i_cascade_ack_unit (
        .clk(clk), .rst_n(rst_n),
        .m_pend_valid(m_pend_valid), .m_pend_line(m_pend_line), .m_base(m_base),
        .s_pend_valid(s_pend_valid), .s_pend_line(s_pend_line), .s_base(s_base),
        .inta(inta), .cascade_req(cascade_req), .drop_cascade(drop_cascade),
        .cpu_int(cpu_int), .vec_valid(vec_valid), .vec_out(vec_out),
        .m_ack(m_ack), .m_ack_line(m_ack_line),
        .s_ack(s_ack), .s_ack_line(s_ack_line)
    );

    // behavioural reference: phase 0 waiting, 1 delivering, 2 settling
    int    phase = 0;
    int    e_vec = 0, e_mline = 0, e_sline = 0;
    bit    e_int = 0, e_vv = 0, e_mack = 0, e_sack = 0;
    string e_tag = "R11";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase = 0; e_vec = 0; e_mline = 0; e_sline = 0;
            e_int = 0; e_vv = 0; e_mack = 0; e_sack = 0; e_tag = "R11";
        end else begin
            bit stale_now;
            bit ok_now;
            stale_now = m_pend_valid && m_pend_line == 3'd2 && !s_pend_valid;
            ok_now    = m_pend_valid && !stale_now;
            e_vv = 0; e_mack = 0; e_sack = 0;
            if (phase == 0 && inta) begin
                phase = 1; e_vv = 1;
                e_mline = m_pend_line; e_sline = s_pend_line;
                if (!m_pend_valid) begin
                    e_vec = (m_base / 8) * 8 + 7; e_tag = "R3";
                end else if (m_pend_line == 3'd2) begin
                    e_mack = 1;
                    if (s_pend_valid) begin
                        e_sack = 1; e_vec = (s_base / 8) * 8 + s_pend_line; e_tag = "R4";
                    end else begin
                        e_vec = (s_base / 8) * 8 + 7; e_tag = "R5";
                    end
                end else begin
                    e_mack = 1; e_vec = (m_base / 8) * 8 + m_pend_line; e_tag = "R6";
                end
            end else if (phase == 1) phase = 2;
            else if (phase == 2) phase = 0;
            e_int = ok_now && phase == 0;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live) begin
            check("R1", "cascade_req", cascade_req, s_pend_valid);
            check("R2", "drop_cascade", drop_cascade,
                  m_pend_valid && m_pend_line == 3'd2 && !s_pend_valid);
            check("R9", "cpu_int", cpu_int, e_int);
            check("R8", "vec_valid", vec_valid, e_vv);
            check(e_tag, "vec_out", vec_out, e_vec);
            check(e_tag, "m_ack", m_ack, e_mack);
            check(e_tag, "s_ack", s_ack, e_sack);
            check("R8", "m_ack_line", m_ack_line, e_mline);
            check("R8", "s_ack_line", s_ack_line, e_sline);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_inta(int len);
        inta = 1'b1; step(len); inta = 1'b0;
    endtask

    initial begin
        int pulses;
        step(2);
        // R11: reset state
        check("R11", "reset outputs", {cpu_int, vec_valid, m_ack, s_ack}, 0);
        check("R11", "reset vec", vec_out, 0);
        rst_n = 1'b1; live = 1;
        step(2);
        // R6/R7: plain primary line 5, base low bits set
        m_pend_valid = 1; m_pend_line = 3'd5; m_base = 8'h27; s_base = 8'h75;
        step(1);
        check("R9", "int raised", cpu_int, 1);
        pulse_inta(1);
        check("R6", "vec line5", vec_out, 8'h25);
        check("R7", "base low bits", vec_out[2:0], 5);
        m_pend_valid = 0;
        step(3);
        check("R9", "int dropped", cpu_int, 0);
        // R4: cascade with live secondary line 3
        s_pend_valid = 1; s_pend_line = 3'd3; m_pend_valid = 1; m_pend_line = 3'd2;
        step(2);
        pulse_inta(1);
        check("R4", "cascade vec", vec_out, 8'h73);
        check("R4", "both acks", {m_ack, s_ack}, 2'b11);
        s_pend_valid = 0; m_pend_valid = 0;
        step(3);
        // R2: stale cascade, then lower primary line takes over
        m_pend_valid = 1; m_pend_line = 3'd2;
        step(1);
        check("R2", "drop strobe", drop_cascade, 1);
        check("R2", "no int stale", cpu_int, 0);
        m_pend_line = 3'd4;
        step(1);
        check("R2", "lower line int", cpu_int, 1);
        // R5: acknowledge while cascade is stale
        m_pend_line = 3'd2;
        pulse_inta(1);
        check("R5", "spurious slave vec", vec_out, 8'h77);
        check("R5", "only master ack", {m_ack, s_ack}, 2'b10);
        m_pend_valid = 0;
        step(3);
        // R3: acknowledge with nothing pending
        m_base = 8'h08;
        pulse_inta(1);
        check("R3", "spurious master vec", vec_out, 8'h0F);
        check("R3", "no acks", {m_ack, s_ack}, 2'b00);
        step(3);
        // R10: held acknowledge
        m_pend_valid = 1; m_pend_line = 3'd0; m_base = 8'hA0;
        step(1);
        pulses = 0;
        inta = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); if (vec_valid) pulses++;
        end
        step(0);
        inta = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); if (vec_valid) pulses++;
        end
        check("R10", "pulses for held inta", pulses, 1);
        check("R8", "vec held", vec_out, 8'hA0);
        step(4);
        live = 0; done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule